// File: doc/BRIEF.md
# Dual-Port SRAM Access Controller

This block places a two-bank SRAM behind two request ports: a primary port for the processor and a secondary port for DMA and network traffic. A 12-bit configuration register controls it. The register holds a global enable, one priority bit for each bank, an enable for the secondary port, a write-protect bit and five access-type masks. In every cycle the block decides whether each request is claimed by the SRAM. It flags CPU writes that are blocked by write protection. It also settles conflicts separately in each bank.

The most significant bit of the word offset selects the bank: 0 selects the lower bank and 1 the upper bank. Requests to different banks proceed in the same clock. Requests to the same bank are resolved by that bank's priority bit, and the losing port waits with its ready signal low. A granted access completes at the next clock edge, and read data appears in the cycle after the grant.

Each bank contains a small read-return state machine. Its states are:
- `BK_IDLE`: no read data is owed.
- `BK_CPU_RD`: the CPU read granted in the previous cycle is being returned.
- `BK_DMA_RD`: the DMA read granted in the previous cycle is being returned.

The transitions, evaluated every cycle, are:
- A granted CPU read moves the bank to `BK_CPU_RD`.
- Otherwise, a granted DMA read moves it to `BK_DMA_RD`.
- Otherwise, including every write, the bank returns to `BK_IDLE`.

Top module: `sdc_ctrl`

## Requirements
- R1: Reset clears the configuration register, so `cfg_rdata` reads 0 and the block is disabled.
- R2: Configuration bits 7 and 6 are reserved. Writes to them are ignored and they read back as 0. Writing 0xFFF reads back as 0xF3F.
- R3: While bit 0 (enable) is 0, `cpu_hit`, `cpu_ready` and `dma_ready` stay low and `dma_refuse` follows `dma_req`.
- R4: `cpu_space` selects the mask bit that applies to a CPU request:
  - 0 (user data) selects bit 1.
  - 1 (user code) selects bit 2.
  - 2 (supervisor data) selects bit 3.
  - 3 (supervisor code) selects bit 4.
  - 4 (CPU space/interrupt acknowledge) selects bit 5.
  - Codes 5 to 7 are never claimed.
  A request whose mask bit is set has `cpu_hit` low and is not served.
- R5: A DMA request is served only when bit 9 (secondary enable), input `dp_en` and the enable bit are all 1. Otherwise `dma_refuse` is high and `dma_ready` is low.
- R6: When bit 8 (write protect) is 1, a claimed CPU write gives `cpu_err=1` and `cpu_ready=1` in the same cycle and leaves the array unchanged. CPU reads and DMA writes are not affected by write protect.
- R7: When both ports target the same bank, that bank's priority bit decides the winner: bit 10 for the lower bank and bit 11 for the upper bank. A value of 0 grants the CPU and 1 grants DMA. The loser has its ready signal low and is served when it requests again alone.
- R8: Requests from the two ports to different banks are both granted in the same cycle.
- R9: A granted read raises that port's `rvalid` in the next cycle, with the word most recently written at that address.
- R10: A configuration write takes effect from the cycle after `cfg_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 12 | Configuration write value |
| cfg_rdata | output | 12 | Configuration readback |
| dp_en | input | 1 | External dual-port enable |
| cpu_req | input | 1 | CPU request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_space | input | 3 | CPU access-type code |
| cpu_addr | input | AW | CPU word offset; MSB selects bank |
| cpu_wdata | input | DW | CPU write data |
| cpu_hit | output | 1 | CPU request claimed by the SRAM |
| cpu_ready | output | 1 | CPU access accepted this cycle |
| cpu_err | output | 1 | Write-protect access error |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | DW | CPU read data |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW | DMA word offset; MSB selects bank |
| dma_wdata | input | DW | DMA write data |
| dma_refuse | output | 1 | DMA request refused |
| dma_ready | output | 1 | DMA access accepted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | DW | DMA read data |

## Verification
The properties assume that request inputs change only between clock edges. They also assume that `cpu_space` and the addresses are stable while a request is high. Read-latency properties further assume that a port does not hold a request through the cycle that returns its own read data with different expectations.

The stimulus changes every input on the falling edge and drops every request one cycle after raising it. Each access is therefore a single-cycle pulse. A losing port is retried only as a fresh request.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int CFG_W = 12;
    localparam logic [CFG_W-1:0] CFG_WMASK = 12'hF3F;

    typedef struct packed {
        logic       pri_hi;
        logic       pri_lo;
        logic       sec_en;
        logic       wr_prot;
        logic [1:0] rsv;
        logic [4:0] amask;
        logic       valid;
    } cfg_t;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_CPU_RD = 2'd1,
        BK_DMA_RD = 2'd2
    } bank_st_e;
endpackage

// File: rtl/sdc_cfg_reg.sv
module sdc_cfg_reg
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    logic [CFG_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & CFG_WMASK;
    end

    assign cfg = cfg_t'(q);
endmodule

// File: rtl/sdc_qual.sv
module sdc_qual (
    input  logic       valid,
    input  logic       sec_en,
    input  logic       wr_prot,
    input  logic [4:0] amask,
    input  logic       dp_en,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic [2:0] cpu_space,
    input  logic       dma_req,
    output logic       cpu_hit,
    output logic       cpu_err,
    output logic       cpu_go,
    output logic       dma_go,
    output logic       dma_refuse
);
    logic space_ok;
    logic masked;

    always_comb begin
        space_ok   = (cpu_space <= 3'd4);
        masked     = space_ok ? amask[cpu_space] : 1'b1;
        cpu_hit    = cpu_req & valid & ~masked;
        cpu_err    = cpu_hit & cpu_we & wr_prot;
        cpu_go     = cpu_hit & ~cpu_err;
        dma_go     = dma_req & valid & sec_en & dp_en;
        dma_refuse = dma_req & ~dma_go;
    end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
    import sdc_pkg::*;
#(
    parameter int IW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pri,
    input  logic          cpu_go,
    input  logic          cpu_we,
    input  logic [IW-1:0] cpu_idx,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          dma_go,
    input  logic          dma_we,
    input  logic [IW-1:0] dma_idx,
    input  logic [DW-1:0] dma_wdata,
    output logic          cpu_gnt,
    output logic          dma_gnt,
    output logic          cpu_rv,
    output logic          dma_rv,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << IW;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rd_q;
    bank_st_e      st, st_nx;

    // fixed priority inside the bank
    always_comb begin
        cpu_gnt = cpu_go & (~dma_go | ~pri);
        dma_gnt = dma_go & (~cpu_go | pri);
    end

    always_comb begin
        st_nx = BK_IDLE;
        if (cpu_gnt && !cpu_we)      st_nx = BK_CPU_RD;
        else if (dma_gnt && !dma_we) st_nx = BK_DMA_RD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BK_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        cpu_rv = 1'b0;
        dma_rv = 1'b0;
        unique case (st)
            BK_IDLE:   ;
            BK_CPU_RD: cpu_rv = 1'b1;
            BK_DMA_RD: dma_rv = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (cpu_gnt) begin
            if (cpu_we) mem[cpu_idx] <= cpu_wdata;
            else        rd_q <= mem[cpu_idx];
        end else if (dma_gnt) begin
            if (dma_we) mem[dma_idx] <= dma_wdata;
            else        rd_q <= mem[dma_idx];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
    import sdc_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             dp_en,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [2:0]       cpu_space,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_hit,
    output logic             cpu_ready,
    output logic             cpu_err,
    output logic             cpu_rvalid,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             dma_req,
    input  logic             dma_we,
    input  logic [AW-1:0]    dma_addr,
    input  logic [DW-1:0]    dma_wdata,
    output logic             dma_refuse,
    output logic             dma_ready,
    output logic             dma_rvalid,
    output logic [DW-1:0]    dma_rdata
);
    localparam int IW    = AW - 1;
    localparam int BANKS = 2;

    cfg_t          cfg;
    logic          cpu_go, dma_go;
    logic [BANKS-1:0] cpu_gnt_v, dma_gnt_v, cpu_rv_v, dma_rv_v;
    logic [DW-1:0] rd_v [BANKS];

    sdc_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
    );

    assign cfg_rdata = cfg;

    sdc_qual u_qual (
        .valid(cfg.valid), .sec_en(cfg.sec_en), .wr_prot(cfg.wr_prot),
        .amask(cfg.amask), .dp_en(dp_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_space(cpu_space),
        .dma_req(dma_req),
        .cpu_hit(cpu_hit), .cpu_err(cpu_err), .cpu_go(cpu_go),
        .dma_go(dma_go), .dma_refuse(dma_refuse)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic pri_b;
        assign pri_b = (b == 0) ? cfg.pri_lo : cfg.pri_hi;

        sdc_bank #(.IW(IW), .DW(DW)) u_bank (
            .clk(clk), .rst_n(rst_n), .pri(pri_b),
            .cpu_go(cpu_go & (cpu_addr[AW-1] == 1'(b))),
            .cpu_we(cpu_we), .cpu_idx(cpu_addr[IW-1:0]), .cpu_wdata(cpu_wdata),
            .dma_go(dma_go & (dma_addr[AW-1] == 1'(b))),
            .dma_we(dma_we), .dma_idx(dma_addr[IW-1:0]), .dma_wdata(dma_wdata),
            .cpu_gnt(cpu_gnt_v[b]), .dma_gnt(dma_gnt_v[b]),
            .cpu_rv(cpu_rv_v[b]), .dma_rv(dma_rv_v[b]),
            .rdata(rd_v[b])
        );
    end

    always_comb begin
        cpu_ready  = cpu_err | (|cpu_gnt_v);
        dma_ready  = |dma_gnt_v;
        cpu_rvalid = |cpu_rv_v;
        dma_rvalid = |dma_rv_v;
        cpu_rdata  = cpu_rv_v[1] ? rd_v[1] : (cpu_rv_v[0] ? rd_v[0] : '0);
        dma_rdata  = dma_rv_v[1] ? rd_v[1] : (dma_rv_v[0] ? rd_v[0] : '0);
    end
endmodule

// File: rtl/sdc_chk.sv
module sdc_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cfg_hi,
    input logic [5:0]    cfg_lo,
    input logic          dp_en,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [2:0]    cpu_space,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_hit,
    input logic          cpu_ready,
    input logic          cpu_err,
    input logic          cpu_rvalid,
    input logic          dma_req,
    input logic          dma_we,
    input logic [AW-1:0] dma_addr,
    input logic          dma_refuse,
    input logic          dma_ready,
    input logic          dma_rvalid
);
    logic masked, same_bank, bank_pri, dma_ok;

    always_comb begin
        masked    = (cpu_space > 3'd4) || cfg_lo[cpu_space + 3'd1];
        same_bank = (cpu_addr[AW-1] == dma_addr[AW-1]);
        bank_pri  = cpu_addr[AW-1] ? cfg_hi[3] : cfg_hi[2];
        dma_ok    = cfg_lo[0] && cfg_hi[1] && dp_en;
    end

    // R3
    valid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_lo[0] |-> (!cpu_hit && !cpu_ready && !dma_ready));

    // R4
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && masked) |-> !cpu_hit);

    // R5
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ok) |-> (dma_refuse && !dma_ready));

    // R6
    wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && cpu_we && cfg_hi[0]) |-> (cpu_err && cpu_ready));

    // R7
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && !cpu_err && dma_req && !dma_refuse && same_bank)
        |-> (cpu_ready == !bank_pri) && (dma_ready == bank_pri));

    // R8
    split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && !cpu_err && dma_req && !dma_refuse && !same_bank)
        |-> (cpu_ready && dma_ready));

    // R9
    cpu_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_err && !cpu_we) |=> cpu_rvalid);

    // R9
    dma_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ready && !dma_we) |=> dma_rvalid);
endmodule

bind sdc_ctrl sdc_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_hi(cfg_rdata[11:8]), .cfg_lo(cfg_rdata[5:0]), .dp_en(dp_en),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_space(cpu_space),
    .cpu_addr(cpu_addr), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready),
    .cpu_err(cpu_err), .cpu_rvalid(cpu_rvalid),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_refuse(dma_refuse), .dma_ready(dma_ready), .dma_rvalid(dma_rvalid)
);

// File: tb/sdc_ctrl_test.sv
module sdc_ctrl_test;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam logic [AW-1:0] UP = 10'd512;
    localparam logic [11:0] C_VAL = 12'h001, C_SEC = 12'h200, C_WP = 12'h100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0, cfg_rdata;
    logic dp_en = 1'b1;
    logic cpu_req = 0, cpu_we = 0;
    logic [2:0] cpu_space = 3'd2;
    logic [AW-1:0] cpu_addr = '0, dma_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, dma_wdata = '0, cpu_rdata, dma_rdata;
    logic cpu_hit, cpu_ready, cpu_err, cpu_rvalid;
    logic dma_req = 0, dma_we = 0, dma_refuse, dma_ready, dma_rvalid;

    int checks = 0, fails = 0;
    bit done = 0;

    logic s_hit, s_cr, s_err, s_dr, s_dref, s_crv, s_drv;
    logic [DW-1:0] s_crd, s_drd;

    always #5 clk = ~clk;

    sdc_ctrl #(.AW(AW), .DW(DW)) uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [11:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic step(input logic cr, input logic cw, input logic [2:0] sp,
                        input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                        input logic dr, input logic dw,
                        input logic [AW-1:0] da, input logic [DW-1:0] dd);
        @(negedge clk);
        cpu_req = cr; cpu_we = cw; cpu_space = sp; cpu_addr = ca; cpu_wdata = cd;
        dma_req = dr; dma_we = dw; dma_addr = da; dma_wdata = dd;
        #1;
        s_hit = cpu_hit; s_cr = cpu_ready; s_err = cpu_err;
        s_dr = dma_ready; s_dref = dma_refuse;
        @(posedge clk); #1;
        s_crv = cpu_rvalid; s_crd = cpu_rdata; s_drv = dma_rvalid; s_drd = dma_rdata;
        cpu_req = 1'b0; dma_req = 1'b0;
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 12'h000, "R1 reset cfg", 32'(cfg_rdata), 0);
        step(1, 0, 3'd2, 10'd3, 0, 1, 0, 10'd600, 0);
        chk(!s_hit && !s_cr, "R3 cpu after reset", {s_hit, s_cr}, 0);
        chk(!s_dr && s_dref, "R3 dma after reset", {s_dr, s_dref}, 1);
    endtask

    task automatic t_reserved;
        set_cfg(12'hFFF);
        chk(cfg_rdata == 12'hF3F, "R2 reserved bits", 32'(cfg_rdata), 32'hF3F);
        set_cfg(C_VAL | C_SEC);
        chk(cfg_rdata == 12'h201, "R10 cfg update", 32'(cfg_rdata), 32'h201);
    endtask

    task automatic t_basic;
        step(1, 1, 3'd2, 10'd5, 32'hA5A5_0005, 0, 0, 0, 0);
        chk(s_hit && s_cr && !s_err, "R9 cpu write", {s_hit, s_cr, s_err}, 3'b110);
        step(1, 0, 3'd2, 10'd5, 0, 0, 0, 0, 0);
        chk(s_crv && s_crd == 32'hA5A5_0005, "R9 cpu read", s_crd, 32'hA5A5_0005);
        step(0, 0, 3'd2, 0, 0, 1, 1, 10'd600, 32'hB00B_0600);
        chk(s_dr && !s_dref, "R5 dma write", {s_dr, s_dref}, 2'b10);
        step(0, 0, 3'd2, 0, 0, 1, 0, 10'd600, 0);
        chk(s_drv && s_drd == 32'hB00B_0600, "R9 dma read", s_drd, 32'hB00B_0600);
        step(0, 0, 3'd2, 0, 0, 1, 0, 10'd5, 0);
        chk(s_drv && s_drd == 32'hA5A5_0005, "R9 dma reads cpu word", s_drd, 32'hA5A5_0005);
    endtask

    task automatic t_prio;
        for (int p = 0; p < 4; p++) begin
            set_cfg(C_VAL | C_SEC | 12'(p << 10));
            for (int b = 0; b < 2; b++) begin
                logic [AW-1:0] base;
                logic [DW-1:0] cv, dv;
                bit cpu_wins;
                base = (b == 1) ? UP : '0;
                cv = 32'hC000_0000 | 32'(p << 4) | 32'(b);
                dv = 32'hD000_0000 | 32'(p << 4) | 32'(b);
                cpu_wins = (((p >> b) & 1) == 0);
                step(1, 1, 3'd0, base + 10'd1, cv, 0, 0, 0, 0);
                step(0, 0, 3'd0, 0, 0, 1, 1, base + 10'd2, dv);
                step(1, 0, 3'd0, base + 10'd1, 0, 1, 0, base + 10'd2, 0);
                chk(s_cr == cpu_wins && s_dr == !cpu_wins, "R7 conflict winner",
                    {s_cr, s_dr}, {cpu_wins, !cpu_wins});
                if (cpu_wins) begin
                    chk(s_crv && !s_drv && s_crd == cv, "R7 cpu won data", s_crd, cv);
                    step(0, 0, 3'd0, 0, 0, 1, 0, base + 10'd2, 0);
                    chk(s_dr && s_drv && s_drd == dv, "R7 dma retry", s_drd, dv);
                end else begin
                    chk(s_drv && !s_crv && s_drd == dv, "R7 dma won data", s_drd, dv);
                    step(1, 0, 3'd0, base + 10'd1, 0, 0, 0, 0, 0);
                    chk(s_cr && s_crv && s_crd == cv, "R7 cpu retry", s_crd, cv);
                end
            end
            step(1, 0, 3'd0, 10'd1, 0, 1, 0, UP + 10'd2, 0);
            chk(s_cr && s_dr, "R8 split banks ready", {s_cr, s_dr}, 2'b11);
            chk(s_crv && s_drv && s_crd == (32'hC000_0000 | 32'(p << 4))
                && s_drd == (32'hD000_0001 | 32'(p << 4)), "R8 split banks data",
                s_crd ^ s_drd, (32'hC000_0000 | 32'(p << 4)) ^ (32'hD000_0001 | 32'(p << 4)));
        end
    endtask

    task automatic t_wp;
        set_cfg(C_VAL | C_SEC);
        step(1, 1, 3'd1, 10'd7, 32'h1111_0007, 0, 0, 0, 0);
        set_cfg(C_VAL | C_SEC | C_WP);
        step(1, 1, 3'd1, 10'd7, 32'h2222_0007, 0, 0, 0, 0);
        chk(s_hit && s_err && s_cr, "R6 wp error", {s_hit, s_err, s_cr}, 3'b111);
        step(1, 0, 3'd1, 10'd7, 0, 0, 0, 0, 0);
        chk(!s_err && s_crv && s_crd == 32'h1111_0007, "R6 array unchanged", s_crd, 32'h1111_0007);
        step(0, 0, 3'd1, 0, 0, 1, 1, 10'd8, 32'h3333_0008);
        chk(s_dr, "R6 dma write under wp", s_dr, 1);
        step(1, 0, 3'd1, 10'd8, 0, 0, 0, 0, 0);
        chk(s_crv && s_crd == 32'h3333_0008, "R6 dma data stored", s_crd, 32'h3333_0008);
    endtask

    task automatic t_mask;
        for (int i = 0; i < 5; i++) begin
            set_cfg(C_VAL | C_SEC | 12'(1 << (i + 1)));
            for (int c = 0; c < 8; c++) begin
                bit exp_hit;
                exp_hit = (c < 5) && (c != i);
                step(1, 0, 3'(c), 10'd5, 0, 0, 0, 0, 0);
                chk(s_hit == exp_hit && s_cr == exp_hit, "R4 mask per type",
                    {s_hit, s_cr}, {exp_hit, exp_hit});
            end
        end
    endtask

    task automatic t_dma_gate;
        set_cfg(C_VAL);
        step(0, 0, 3'd2, 0, 0, 1, 0, 10'd600, 0);
        chk(s_dref && !s_dr, "R5 sec disabled", {s_dref, s_dr}, 2'b10);
        set_cfg(C_VAL | C_SEC);
        dp_en = 1'b0;
        step(0, 0, 3'd2, 0, 0, 1, 0, 10'd600, 0);
        chk(s_dref && !s_dr, "R5 dp_en low", {s_dref, s_dr}, 2'b10);
        dp_en = 1'b1;
        step(0, 0, 3'd2, 0, 0, 1, 0, 10'd600, 0);
        chk(!s_dref && s_dr, "R5 enabled", {s_dref, s_dr}, 2'b01);
    endtask

    task automatic t_valid;
        set_cfg(C_SEC);
        step(1, 0, 3'd2, 10'd5, 0, 1, 0, 10'd600, 0);
        chk(!s_hit && !s_cr && !s_dr && s_dref, "R3 valid clear",
            {s_hit, s_cr, s_dr, s_dref}, 4'b0001);
        set_cfg(C_VAL | C_SEC);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk(cfg_rdata == 12'h000, "R1 reset mid-run", 32'(cfg_rdata), 0);
        step(1, 0, 3'd2, 10'd5, 0, 0, 0, 0, 0);
        chk(!s_hit && !s_cr, "R3 after mid-run reset", {s_hit, s_cr}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        t_reset();
        t_reserved();
        t_basic();
        t_prio();
        t_wp();
        t_mask();
        t_dma_gate();
        t_valid();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule